// File: doc/BRIEF.md
# Low-Resolution VGA Framebuffer Controller

This block drives a VGA monitor in the 640x400, 70 Hz mode from a 25.175 MHz pixel clock. The picture comes from a 160x100 framebuffer of one byte per pixel held in on-chip RAM. Each stored pixel is blown up to a 4x4 block so that the stored picture fills the whole visible area. A processor fills the framebuffer through a port that can only write. The scan-out logic alone reads the RAM.

Stored bytes are RGB332. The block widens them to 6 bits per colour channel for a resistor-ladder DAC. Two effects are applied on top of the picture. An optional scanline effect darkens every odd output line. A hardware cursor, a white square placed in framebuffer coordinates, is painted over the picture, so software never needs to read video memory back to draw or restore it.

Timing, framebuffer size, scale factor, cursor size and output width are parameters. The defaults give the mode described here.

Top module: `lowresVga`

## Requirements
- R1: A line lasts H_ACTIVE+H_FRONT+H_SYNC+H_BACK clocks (default 640+16+96+48=800). With the horizontal position counted from 0 at the start of the line, `hsyncN` is low for positions H_ACTIVE+H_FRONT up to, but not including, H_ACTIVE+H_FRONT+H_SYNC (default 656..751). It is high at every other position.
- R2: A frame lasts V_ACTIVE+V_FRONT+V_SYNC+V_BACK lines (default 400+12+2+35=449). The line number advances only when a line ends. `vsync` is high on lines V_ACTIVE+V_FRONT up to, but not including, V_ACTIVE+V_FRONT+V_SYNC (default lines 412 and 413) and low elsewhere.
- R3: A write with `wrEn` high on a rising edge stores `wrData` at `wrAddr`. The address of framebuffer pixel (x, y) is y*FB_W+x. A read of the same address on that same edge returns the byte held before the write.
- R4: At line position h and line v inside the active area, the displayed byte is the one stored at address (v>>SCALE_LOG2)*FB_W+(h>>SCALE_LOG2). With the default SCALE_LOG2=2, each stored pixel covers a 4x4 block of screen pixels.
- R5: A displayed byte p is treated as RGB332, with red in p[7:5], green in p[4:2] and blue in p[1:0]. It is shown as red = {p[7:5],p[7:5]}, green = {p[4:2],p[4:2]} and blue = {p[1:0],p[1:0],p[1:0]}.
- R6: Outside the active area (h >= H_ACTIVE or v >= V_ACTIVE), `red`, `green` and `blue` are all 0.
- R7: While `scanEn` is high, every channel on an odd line v is shifted right by one bit, after the cursor is applied. While `scanEn` is low, odd lines are shown unchanged.
- R8: When `curEn` is high, every screen pixel whose framebuffer column lies in [curX, curX+CUR_SIZE) and whose framebuffer row lies in [curY, curY+CUR_SIZE) is shown as full white (all channel bits 1). Cells of the cursor that fall past the framebuffer edge are simply not drawn.
- R9: Reset (`rstN` low, asynchronous) sets both counters to 0 and drives `hsyncN` high, `vsync` low and all colour outputs to 0. After reset is released, each output shows the values for the counter position held just before the previous rising edge, so the outputs lag the counter position by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Framebuffer write strobe |
| wrAddr | input | $clog2(FB_W*FB_H) (14) | Write address, y*FB_W+x |
| wrData | input | 8 | RGB332 pixel byte to store |
| scanEn | input | 1 | Turns on darkening of odd lines |
| curEn | input | 1 | Shows the hardware cursor |
| curX | input | $clog2(FB_W) (8) | Cursor left column, in framebuffer pixels |
| curY | input | $clog2(FB_H) (7) | Cursor top row, in framebuffer pixels |
| hsyncN | output | 1 | Horizontal sync, active low |
| vsync | output | 1 | Vertical sync, active high |
| red | output | OUT_W (6) | Red level |
| green | output | OUT_W (6) | Green level |
| blue | output | OUT_W (6) | Blue level |

## Verification
Every output belongs to the counter position held one clock earlier. The RAM read and the strobe stage are the only registers between the counters and the pins. A write reaches the screen on the first read of its address that follows the write edge, and a read on the write edge itself still returns the old byte. The bench reference model advances its own line and frame position on every rising edge. At that edge it computes the expected outputs from the position and inputs before the edge, and only then applies any pending write. It compares on the next falling edge, so each comparison waits exactly the one-register latency. Changes to cursor and scanline inputs are made at falling edges, so they act from the next pixel onward.

// File: rtl/lowresVgaPkg.sv
package lowresVgaPkg;

  // Per-pixel strobes handed from the scan control to the pixel datapath.
  typedef struct packed {
    logic active;   // inside the visible window
    logic hsync;    // horizontal sync pulse (true = in pulse)
    logic vsync;    // vertical sync pulse (true = in pulse)
    logic dim;      // scanline darkening for this line
    logic curHit;   // cursor covers this pixel
  } scanStrobe_t;

endpackage

// File: rtl/vgaScanCtrl.sv
module vgaScanCtrl
  import lowresVgaPkg::*;
#(
  parameter int H_ACTIVE  = 640,
  parameter int H_FRONT   = 16,
  parameter int H_SYNC    = 96,
  parameter int H_BACK    = 48,
  parameter int V_ACTIVE  = 400,
  parameter int V_FRONT   = 12,
  parameter int V_SYNC    = 2,
  parameter int V_BACK    = 35,
  parameter int FB_W      = 160,
  parameter int FB_H      = 100,
  parameter int SCALE_LOG2 = 2,
  parameter int CUR_SIZE  = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic scanEn,
  input  logic curEn,
  input  logic [$clog2(FB_W)-1:0] curX,
  input  logic [$clog2(FB_H)-1:0] curY,
  output scanStrobe_t strb,
  output logic [$clog2(FB_W*FB_H)-1:0] rdAddr
);
  localparam int H_TOTAL  = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOTAL  = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam int HW       = $clog2(H_TOTAL);
  localparam int VW       = $clog2(V_TOTAL);
  localparam int XW       = $clog2(FB_W);
  localparam int YW       = $clog2(FB_H);
  localparam int AW       = $clog2(FB_W * FB_H);
  localparam int HS_START = H_ACTIVE + H_FRONT;
  localparam int HS_END   = HS_START + H_SYNC;
  localparam int VS_START = V_ACTIVE + V_FRONT;
  localparam int VS_END   = VS_START + V_SYNC;

  logic [HW-1:0] hCnt;
  logic [VW-1:0] vCnt;
  logic lineEnd, frameEnd;
  logic [XW-1:0] fbX;
  logic [YW-1:0] fbY;
  logic [XW:0] xLo, xHi;
  logic [YW:0] yLo, yHi;
  logic inCurX, inCurY;

  assign lineEnd  = (hCnt == HW'(H_TOTAL - 1));
  assign frameEnd = (vCnt == VW'(V_TOTAL - 1));

  // Pixel counter every clock, line counter once per line.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (lineEnd) begin
      hCnt <= '0;
      vCnt <= frameEnd ? '0 : vCnt + 1'b1;
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  // Framebuffer coordinates after the down-scale.
  assign fbX = XW'(hCnt >> SCALE_LOG2);
  assign fbY = YW'(vCnt >> SCALE_LOG2);

  // Cursor window, one spare bit so the right/bottom bound cannot wrap.
  assign xLo    = {1'b0, curX};
  assign xHi    = xLo + (XW + 1)'(CUR_SIZE);
  assign yLo    = {1'b0, curY};
  assign yHi    = yLo + (YW + 1)'(CUR_SIZE);
  assign inCurX = ({1'b0, fbX} >= xLo) && ({1'b0, fbX} < xHi);
  assign inCurY = ({1'b0, fbY} >= yLo) && ({1'b0, fbY} < yHi);

  always_comb begin
    strb.active = (hCnt < HW'(H_ACTIVE)) && (vCnt < VW'(V_ACTIVE));
    strb.hsync  = (hCnt >= HW'(HS_START)) && (hCnt < HW'(HS_END));
    strb.vsync  = (vCnt >= VW'(VS_START)) && (vCnt < VW'(VS_END));
    strb.dim    = scanEn & vCnt[0];
    strb.curHit = curEn & inCurX & inCurY;
    rdAddr      = strb.active ? AW'(int'(fbY) * FB_W + int'(fbX)) : '0;
  end

  // R1: pixel counter wraps at the end of the line and steps by one otherwise
  a_r1_hcnt_wrap: assert property (@(posedge clk) disable iff (!rstN)
    lineEnd |=> (hCnt == '0));
  a_r1_hcnt_step: assert property (@(posedge clk) disable iff (!rstN)
    !lineEnd |=> (hCnt == $past(hCnt) + 1'b1));
  // R2: line counter only moves when a line ends
  a_r2_vcnt_hold: assert property (@(posedge clk) disable iff (!rstN)
    !lineEnd |=> $stable(vCnt));
  // R2: the vertical pulse only starts or stops at a line boundary
  a_r2_vsync_edge: assert property (@(posedge clk) disable iff (!rstN)
    (strb.vsync != $past(strb.vsync)) |-> (hCnt == '0));
  // R4: scan-out never reads past the framebuffer
  a_r4_addr_range: assert property (@(posedge clk) disable iff (!rstN)
    strb.active |-> (int'(rdAddr) < FB_W * FB_H));

endmodule

// File: rtl/vgaPixelPath.sv
module vgaPixelPath
  import lowresVgaPkg::*;
#(
  parameter int FB_W  = 160,
  parameter int FB_H  = 100,
  parameter int OUT_W = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [$clog2(FB_W*FB_H)-1:0] wrAddr,
  input  logic [7:0] wrData,
  input  scanStrobe_t strb,
  input  logic [$clog2(FB_W*FB_H)-1:0] rdAddr,
  output logic hsyncN,
  output logic vsync,
  output logic [OUT_W-1:0] red,
  output logic [OUT_W-1:0] green,
  output logic [OUT_W-1:0] blue
);
  localparam int DEPTH = FB_W * FB_H;

  logic [7:0] fbMem [DEPTH];
  logic [7:0] pixQ;
  scanStrobe_t stgQ;
  logic [OUT_W-1:0] rW, gW, bW;

  // Widen a w-bit field to OUT_W bits by repeating its bits from the top.
  function automatic logic [OUT_W-1:0] widen(input logic [2:0] v, input int w);
    logic [OUT_W-1:0] o;
    for (int i = 0; i < OUT_W; i++) o[OUT_W-1-i] = v[w-1-(i % w)];
    return o;
  endfunction

  // Write-only CPU port; the scan read sees the pre-write byte.
  always_ff @(posedge clk) begin
    if (wrEn) fbMem[wrAddr] <= wrData;
    pixQ <= fbMem[rdAddr];
  end

  // Strobes travel one stage to stay aligned with the RAM output.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stgQ <= '0;
    else       stgQ <= strb;
  end

  always_comb begin
    rW = widen(pixQ[7:5], 3);
    gW = widen(pixQ[4:2], 3);
    bW = widen({1'b0, pixQ[1:0]}, 2);
    if (stgQ.curHit) begin
      rW = '1;
      gW = '1;
      bW = '1;
    end
    if (stgQ.dim) begin
      rW = rW >> 1;
      gW = gW >> 1;
      bW = bW >> 1;
    end
    if (!stgQ.active) begin
      rW = '0;
      gW = '0;
      bW = '0;
    end
  end

  assign red    = rW;
  assign green  = gW;
  assign blue   = bW;
  assign hsyncN = ~stgQ.hsync;
  assign vsync  = stgQ.vsync;

  // R6: blanking outside the window
  a_r6_blank: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(strb.active)) |-> (red == '0 && green == '0 && blue == '0));
  // R8: an undimmed cursor pixel is full white
  a_r8_cursor_white: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strb.active && strb.curHit && !strb.dim)) |-> (&{red, green, blue}));
  // R7: a dimmed pixel never reaches the top half of the range
  a_r7_dim_top: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strb.active && strb.dim)) |->
      (!red[OUT_W-1] && !green[OUT_W-1] && !blue[OUT_W-1]));
  // R9: sync pins lag the control strobes by exactly one clock
  a_r9_sync_latency: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (hsyncN == !$past(strb.hsync) && vsync == $past(strb.vsync)));

endmodule

// File: rtl/lowresVga.sv
module lowresVga
  import lowresVgaPkg::*;
#(
  parameter int H_ACTIVE   = 640,
  parameter int H_FRONT    = 16,
  parameter int H_SYNC     = 96,
  parameter int H_BACK     = 48,
  parameter int V_ACTIVE   = 400,
  parameter int V_FRONT    = 12,
  parameter int V_SYNC     = 2,
  parameter int V_BACK     = 35,
  parameter int FB_W       = 160,
  parameter int FB_H       = 100,
  parameter int SCALE_LOG2 = 2,
  parameter int CUR_SIZE   = 4,
  parameter int OUT_W      = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [$clog2(FB_W*FB_H)-1:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic scanEn,
  input  logic curEn,
  input  logic [$clog2(FB_W)-1:0] curX,
  input  logic [$clog2(FB_H)-1:0] curY,
  output logic hsyncN,
  output logic vsync,
  output logic [OUT_W-1:0] red,
  output logic [OUT_W-1:0] green,
  output logic [OUT_W-1:0] blue
);
  localparam int AW = $clog2(FB_W * FB_H);

  scanStrobe_t strb;
  logic [AW-1:0] rdAddr;

  vgaScanCtrl #(
    .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
    .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK),
    .FB_W(FB_W), .FB_H(FB_H), .SCALE_LOG2(SCALE_LOG2), .CUR_SIZE(CUR_SIZE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .curEn(curEn),
    .curX(curX), .curY(curY), .strb(strb), .rdAddr(rdAddr)
  );

  vgaPixelPath #(
    .FB_W(FB_W), .FB_H(FB_H), .OUT_W(OUT_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .rdAddr(rdAddr), .hsyncN(hsyncN), .vsync(vsync),
    .red(red), .green(green), .blue(blue)
  );

endmodule

// File: tb/sim_lowresVga.sv
`timescale 1ns/1ps
module sim_lowresVga;
  localparam int FW = 16, FH = 8, SL = 2, CS = 4;
  localparam int HA = 64, HF = 4, HS = 8, HB = 4;
  localparam int VA = 32, VF = 2, VS = 2, VB = 3;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int DEPTH = FW * FH;
  localparam int FRAME = HT * VT;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [$clog2(DEPTH)-1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic scanEn = 1'b0, curEn = 1'b0;
  logic [$clog2(FW)-1:0] curX = '0;
  logic [$clog2(FH)-1:0] curY = '0;
  logic hsyncN, vsync;
  logic [5:0] red, green, blue;

  lowresVga #(
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
    .FB_W(FW), .FB_H(FH), .SCALE_LOG2(SL), .CUR_SIZE(CS), .OUT_W(6)
  ) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .scanEn(scanEn), .curEn(curEn), .curX(curX), .curY(curY),
    .hsyncN(hsyncN), .vsync(vsync), .red(red), .green(green), .blue(blue)
  );

  int checks = 0, fails = 0;
  logic checking = 1'b0;

  // Behavioural reference: its own line/frame position and a byte array.
  logic [7:0] refMem [DEPTH];
  int mh = 0, mv = 0, fx, fy;
  logic [7:0] pix;
  logic expHsN = 1'b1, expVs = 1'b0;
  logic [5:0] expR = '0, expG = '0, expB = '0;
  string ctag = "R9";

  always @(posedge clk) begin
    if (!rstN) begin
      mh = 0; mv = 0;
      expHsN = 1'b1; expVs = 1'b0;
      expR = '0; expG = '0; expB = '0; ctag = "R9";
    end else begin
      fx = mh >> SL;
      fy = mv >> SL;
      expHsN = !(mh >= HA + HF && mh < HA + HF + HS);   // R1
      expVs  = (mv >= VA + VF && mv < VA + VF + VS);    // R2
      if (mh < HA && mv < VA) begin
        pix  = refMem[fy * FW + fx];                    // R3 R4
        expR = {pix[7:5], pix[7:5]};                    // R5
        expG = {pix[4:2], pix[4:2]};
        expB = {pix[1:0], pix[1:0], pix[1:0]};
        ctag = "R3 R4 R5";
        if (curEn && fx >= curX && fx < curX + CS && fy >= curY && fy < curY + CS) begin
          expR = 6'd63; expG = 6'd63; expB = 6'd63; ctag = "R8";
        end
        if (scanEn && (mv % 2 == 1)) begin
          expR = expR >> 1; expG = expG >> 1; expB = expB >> 1; ctag = "R7";
        end
      end else begin
        expR = '0; expG = '0; expB = '0; ctag = "R6";
      end
      mh = mh + 1;
      if (mh == HT) begin
        mh = 0;
        mv = (mv == VT - 1) ? 0 : mv + 1;
      end
    end
    if (wrEn) refMem[wrAddr] = wrData;  // after the read: old byte wins on same edge
  end

  task automatic check(input logic ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Per-clock comparison, away from the active edge.
  always @(negedge clk) begin
    if (checking) begin
      check(hsyncN === expHsN, "R1", "hsyncN", int'(hsyncN), int'(expHsN));
      check(vsync === expVs, "R2", "vsync", int'(vsync), int'(expVs));
      check({red, green, blue} === {expR, expG, expB}, ctag, "rgb",
            int'({red, green, blue}), int'({expR, expG, expB}));
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    checking = 1'b1;
    // R3: fill the framebuffer while reset holds the scan still
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      wrEn = 1'b1; wrAddr = $clog2(DEPTH)'(a); wrData = 8'(a * 29 + 3);
    end
    @(negedge clk);
    wrEn = 1'b0;
    // R9: reset state
    check(hsyncN === 1'b1 && vsync === 1'b0, "R9", "sync reset", int'({hsyncN, vsync}), 2);
    check({red, green, blue} === '0, "R9", "rgb reset", int'({red, green, blue}), 0);
    rstN = 1'b1;
    // R9: one clock later pixel 0 (byte 3 => red 0, green 0, blue 63) is on the pins
    @(negedge clk);
    check(red === 6'd0 && green === 6'd0 && blue === 6'd63, "R9", "first pixel",
          int'({red, green, blue}), 63);

    // R3: rewrites while the picture is being scanned
    repeat (400) @(negedge clk);
    for (int k = 0; k < 40; k++) begin
      wrEn = 1'b1; wrAddr = $clog2(DEPTH)'((k * 7) % DEPTH); wrData = 8'(k * 53 + 11);
      @(negedge clk);
    end
    wrEn = 1'b0;
    repeat (2 * FRAME) @(negedge clk);

    // R7: scanline darkening on
    scanEn = 1'b1;
    repeat (FRAME) @(negedge clk);

    // R8: cursor clipped at the bottom-right corner
    scanEn = 1'b0; curEn = 1'b1; curX = 4'd14; curY = 3'd6;
    repeat (FRAME) @(negedge clk);

    // R7 R8: cursor inside the picture with darkening
    curX = 4'd3; curY = 3'd2; scanEn = 1'b1;
    repeat (FRAME) @(negedge clk);
    curEn = 1'b0;
    repeat (HT * 6) @(negedge clk);

    summary();
    $finish;
  end

endmodule